// File: doc/BRIEF.md
# TDM Frame Timing Generator

This block derives the frame and clock timing for a time-division-multiplexed switch. It runs on a 16.384 MHz master clock and takes two inputs: a 4.096 MHz clock input that is phase-locked to the master clock, and an active-low 8 kHz frame input. Both are sampled in the master clock domain. The frame boundary is taken as the first falling edge of the 4.096 MHz input that comes after a falling edge of the frame input. An 11-bit position counter spans one 2048-cycle frame. It is reloaded to zero at each detected boundary and otherwise wraps freely.

All outputs are decoded from that counter:
- a regenerated active-low frame pulse centred on the boundary;
- a 4.096 MHz clock and a 2.048 MHz clock, phase-aligned to the frame pulse;
- an early active-low pulse for the connection memory;
- a complementary pair that toggles once per frame for the data memory, giving a 4 kHz signal.

A select input chooses between two offset variants for the memory pulses. Before the first boundary after reset, the frame pulses stay inactive.

Top module: `tdm_frame_timer`

## Requirements
- R1: After reset and until the first detected boundary, frame_out_n and cm_pulse_n are 1, dm_frame is 0 and dm_frame_n is 1.
- R2: A boundary is detected at the first master-clock edge where c4_in is sampled 0 after being sampled 1, strictly after the edge that saw frame_in_n go from 1 to 0. A c4_in fall at the same edge as the frame_in_n fall does not count. At that edge the frame position becomes 0.
- R3: Once synchronised, frame_out_n is 0 exactly at frame positions 2046, 2047, 0 and 1, and 1 elsewhere.
- R4: c4_out equals bit 1 of the frame position, so its falling edge lands between positions 2047 and 0, mid-way through the frame pulse.
- R5: c2_out is the inverse of bit 2 of the frame position, so its rising edge lands between positions 2047 and 0.
- R6: With offset_sel = 0 and once synchronised, cm_pulse_n is 0 at positions 1977 to 1980, which starts 71 cycles before the boundary.
- R7: With offset_sel = 1 and once synchronised, cm_pulse_n is 0 at positions 1980 to 1983, which starts 68 cycles before the boundary.
- R8: Once synchronised, dm_frame inverts on entering position 64 (offset_sel = 0) or position 65 (offset_sel = 1), and at no other time. It therefore runs at half the frame rate.
- R9: dm_frame_n is always the complement of dm_frame.
- R10: Without a new boundary, the position advances by one per master clock and wraps from 2047 to 0.
- R11: A boundary that arrives at any position reloads the position to 0, and all outputs follow the new alignment at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c4_in | input | 1 | 4.096 MHz clock input, locked to clk |
| frame_in_n | input | 1 | Active-low 8 kHz frame input |
| offset_sel | input | 1 | Selects the memory-pulse offset variant |
| frame_out_n | output | 1 | Regenerated active-low frame pulse |
| c4_out | output | 1 | 4.096 MHz clock output |
| c2_out | output | 1 | 2.048 MHz clock output |
| cm_pulse_n | output | 1 | Active-low connection-memory early pulse |
| dm_frame | output | 1 | 4 kHz data-memory frame signal |
| dm_frame_n | output | 1 | Complement of dm_frame |

## Verification
The assertions assume that c4_in and frame_in_n are already synchronous to clk, and that offset_sel changes only between clock edges, so the value seen at an edge is the one decoded. They do not assume that boundaries arrive one frame apart: the count and toggle properties are written to survive a reload at any position. The stimulus changes every input on the falling clock edge. Besides a steady 4.096 MHz pattern with periodic frame pulses, it inserts random phase slips of c4_in, frame pulses at random offsets, and mode flips. It also drives one frame fall that coincides with a c4_in fall.

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer #(
  parameter int CW       = 11,
  parameter int CM_LEAD0 = 71,
  parameter int CM_LEAD1 = 68,
  parameter int CM_WIDTH = 4,
  parameter int DM_LAG0  = 64,
  parameter int DM_LAG1  = 65,
  parameter int FP_HALF  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic c4_in,
  input  logic frame_in_n,
  input  logic offset_sel,
  output logic frame_out_n,
  output logic c4_out,
  output logic c2_out,
  output logic cm_pulse_n,
  output logic dm_frame,
  output logic dm_frame_n
);
  localparam int FLEN = 1 << CW;

  logic [CW-1:0] cnt, cnt_nxt, cm_lo, dm_pt;
  logic          c4_q, fr_q, armed, synced, dm;
  logic          c4_fall, fr_fall, bound, in_fp, in_cm;

  assign c4_fall = c4_q & ~c4_in;
  assign fr_fall = fr_q & ~frame_in_n;
  assign bound   = armed & c4_fall;
  assign cnt_nxt = bound ? '0 : cnt + 1'b1;

  assign cm_lo = offset_sel ? CW'(FLEN - CM_LEAD1) : CW'(FLEN - CM_LEAD0);
  assign dm_pt = offset_sel ? CW'(DM_LAG1) : CW'(DM_LAG0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      c4_q   <= 1'b0;
      fr_q   <= 1'b1;
      armed  <= 1'b0;
      synced <= 1'b0;
      dm     <= 1'b0;
    end else begin
      c4_q  <= c4_in;
      fr_q  <= frame_in_n;
      armed <= fr_fall | (armed & ~bound);
      cnt   <= cnt_nxt;
      if (bound) synced <= 1'b1;
      if ((synced | bound) && cnt_nxt == dm_pt) dm <= ~dm;
    end
  end

  assign in_fp = (cnt >= CW'(FLEN - FP_HALF)) || (cnt < CW'(FP_HALF));
  assign in_cm = ({1'b0, cnt} >= {1'b0, cm_lo}) &&
                 ({1'b0, cnt} <  {1'b0, cm_lo} + (CW+1)'(CM_WIDTH));

  assign frame_out_n = ~(synced & in_fp);
  assign cm_pulse_n  = ~(synced & in_cm);
  assign c4_out      = cnt[1];
  assign c2_out      = ~cnt[2];
  assign dm_frame    = dm;
  assign dm_frame_n  = ~dm;
endmodule

// File: rtl/tdm_frame_timer_chk.sv
module tdm_frame_timer_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          offset_sel,
  input logic          synced,
  input logic          bound,
  input logic [CW-1:0] cnt,
  input logic          frame_out_n,
  input logic          c4_out,
  input logic          c2_out,
  input logic          cm_pulse_n,
  input logic          dm_frame,
  input logic          dm_frame_n
);
  p_idle_outputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> (frame_out_n && cm_pulse_n && !dm_frame && dm_frame_n));

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bound |=> (cnt == '0 && synced && !frame_out_n));

  p_clock_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_out_n |-> (c4_out != c2_out));

  p_cm_frame_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_pulse_n |-> frame_out_n);

  p_dm_toggle_point_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dm_frame) |-> (synced && cnt == ($past(offset_sel) ? CW'(65) : CW'(64))));

  p_dm_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dm_frame_n != dm_frame);

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bound |=> cnt == CW'($past(cnt) + 1'b1));
endmodule

bind tdm_frame_timer tdm_frame_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .offset_sel(offset_sel), .synced(synced),
  .bound(bound), .cnt(cnt), .frame_out_n(frame_out_n), .c4_out(c4_out),
  .c2_out(c2_out), .cm_pulse_n(cm_pulse_n), .dm_frame(dm_frame),
  .dm_frame_n(dm_frame_n)
);

// File: tb/tdm_frame_timer_bench.sv
`timescale 1ns/1ps
module tdm_frame_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, c4_in = 1'b0, frame_in_n = 1'b1, offset_sel = 1'b0;
  logic frame_out_n, c4_out, c2_out, cm_pulse_n, dm_frame, dm_frame_n;

  int tests = 0, fails = 0;
  int pos = 0, ph = 0, fr_left = 0;
  bit synced = 0, arm = 0, pc4 = 0, pfr = 1, edm = 0;

  always #2.5 clk = ~clk;

  tdm_frame_timer u_tdm_frame_timer (
    .clk(clk), .rst_n(rst_n), .c4_in(c4_in), .frame_in_n(frame_in_n),
    .offset_sel(offset_sel), .frame_out_n(frame_out_n), .c4_out(c4_out),
    .c2_out(c2_out), .cm_pulse_n(cm_pulse_n), .dm_frame(dm_frame),
    .dm_frame_n(dm_frame_n)
  );

  function automatic bit exp_fp(int p, bit s);
    return !(s && (p >= 2046 || p <= 1));
  endfunction
  function automatic bit exp_cm(int p, bit s, bit m);
    int lo = m ? 1980 : 1977;
    return !(s && p >= lo && p <= lo + 3);
  endfunction

  task automatic cmp(string req, string tag, logic act, logic expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s (%s) pos=%0d actual=%b expected=%b", req, tag, pos, act, expv);
    end
  endtask

  task automatic check_all(string tag);
    cmp(synced ? "R3" : "R1", tag, frame_out_n, exp_fp(pos, synced));
    cmp("R4", tag, c4_out, 1'((pos >> 1) & 1));
    cmp("R5", tag, c2_out, 1'(~((pos >> 2) & 1)));
    cmp(offset_sel ? "R7" : "R6", tag, cm_pulse_n, exp_cm(pos, synced, offset_sel));
    cmp("R8", tag, dm_frame, edm);
    cmp("R9", tag, dm_frame_n, ~edm);
  endtask

  task automatic drive_and_model();
    bit c4v, frv, c4f, ff, bnd;
    c4v = ((ph % 4) >= 2);
    ph++;
    frv = (fr_left == 0);
    if (fr_left > 0) fr_left--;
    c4_in = c4v;
    frame_in_n = frv;
    c4f = pc4 && !c4v;
    ff  = pfr && !frv;
    bnd = arm && c4f;
    arm = ff ? 1'b1 : (bnd ? 1'b0 : arm);
    pc4 = c4v;
    pfr = frv;
    if (bnd) begin pos = 0; synced = 1; end
    else pos = (pos + 1) % 2048;
    if (synced && pos == (offset_sel ? 65 : 64)) edm = ~edm;
  endtask

  task automatic run(int n, int period, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all(tag);
      if (period > 0 && (i % period) == 0) fr_left = 4;
      drive_and_model();
    end
  endtask

  task automatic align_c4_fall();
    while ((ph % 4) != 0) begin
      @(negedge clk);
      check_all("align");
      drive_and_model();
    end
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_all("reset R1");
    rst_n = 1'b1;
    drive_and_model();
    run(300, 0, "unsynced R1");
    align_c4_fall();
    run(3 * 2048, 2048, "coincident R2");
    offset_sel = 1'b1;
    run(2 * 2048, 2048, "mode1 R7");
    offset_sel = 1'b0;
    run(2 * 2048 + 37, 0, "freerun R10");
    for (int k = 0; k < 6; k++) begin
      ph += 1 + int'($urandom_range(2));
      offset_sel = 1'($urandom_range(1));
      run(1 + int'($urandom_range(2999)), 0, "slip R11");
      run(2048 + int'($urandom_range(500)), 2048, "resync R11");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule